// File: doc/BRIEF.md
# Multiply Dispatcher for an Eight-Entry Floating-Point Register Stack

This block holds an eight-entry stack of 80-bit extended-precision registers together with a 3-bit top pointer and one valid tag per register. It accepts one multiply instruction at a time as an opcode byte and an addressing byte. It maps the relative stack names to physical registers and converts a memory operand to extended precision when there is one. It then sends both operands to an external multiply datapath and waits for the product.

When the product returns, the block writes it into the register chosen by the encoding. Some encodings also pop the stack in the same cycle. If an operand register is empty, the block raises a stack-fault pulse and clears condition bit C1. In that case it does not touch the stack at all. A side port pushes values onto the stack so that operands can be loaded.

Top module: `fpstk_mul_dispatch`

## Requirements
- R1: After reset the top pointer is 0, all eight tags are empty, `in_ready` is 1, `mul_req_valid` is 0, `flt_stack` is 0 and `flg_c1` is 0.
- R2: A cycle with `ld_valid` high while no multiply is in flight decrements the top pointer modulo 8. It writes `ld_data` into the register at the new top and sets that tag. `in_ready` is 0 in any cycle in which `ld_valid` is 1.
- R3: Stack name ST(i) refers to physical register (top+i) mod 8. `mul_req_a` always carries ST(0).
- R4: With addressing-byte mode bits [7:6] equal to 3 and the middle field [5:3] equal to 1, opcode D8 multiplies ST(0) by ST(i) into ST(0), where i is bits [2:0]. Opcode DC multiplies ST(i) by ST(0) into ST(i). Opcode DE does the same as DC and then pops. `mul_req_b` carries ST(i).
- R5: With mode bits not equal to 3 and the middle field equal to 1, the operand comes from `in_mem` and the result goes to ST(0). D8 takes an IEEE single from bits [31:0] and DC takes an IEEE double from bits [63:0]. `mul_req_b` carries the operand as sign(1), exponent(15, bias 16383) and a 64-bit significand with an explicit integer bit. Infinities map to exponent 7FFF, and single denormals are normalised.
- R6: DA takes a signed 32-bit integer from bits [31:0] and DE takes a signed 16-bit integer from bits [15:0]. Both are converted exactly to the same extended format, and integer zero becomes +0.
- R7: A popping form writes the product first, then clears the tag of the register that was ST(0) and increments the top pointer, all in the commit cycle. When the destination is ST(0) itself, that register ends up empty.
- R8: If ST(0) is empty, or ST(i) is empty in a register form, `flt_stack` pulses for one cycle after acceptance and `flg_c1` becomes 0. No request is issued, no register is written and nothing is popped.
- R9: On a commit, `flg_c1` takes the value of `mul_rsp_c1`.
- R10: `mul_req_valid` is a one-cycle pulse in the cycle after acceptance. `in_ready` stays 0 from then until the cycle after `mul_rsp_valid` is seen.
- R11: An encoding other than the eight listed is accepted and has no effect: no request, no fault, and the stack is unchanged. This covers a middle field other than 1, DA with mode 3, and any other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_opcode | input | 8 | Primary opcode byte |
| in_modrm | input | 8 | Addressing byte (mode, middle field, register index) |
| in_mem | input | 64 | Memory operand, low-aligned |
| ld_valid | input | 1 | Push request |
| ld_data | input | 80 | Value to push |
| mul_req_valid | output | 1 | Operands valid for the multiplier |
| mul_req_a | output | 80 | ST(0) operand |
| mul_req_b | output | 80 | Second operand |
| mul_rsp_valid | input | 1 | Product returned |
| mul_rsp_data | input | 80 | Product |
| mul_rsp_c1 | input | 1 | Product was rounded up |
| flt_stack | output | 1 | Stack-underflow fault pulse |
| flg_c1 | output | 1 | Condition bit C1 |
| stk_top | output | 3 | Top pointer |
| stk_tags | output | 8 | Valid tag per physical register |

## Verification
Writeback and pop land in the same commit cycle. They collide when the popping encoding names ST(0) as its own destination. The bench provokes this with DE and index 0, after a DE with index 1 has moved the top pointer. The outcome is judged at the ports: the tag of that register must read empty and the top pointer must have advanced. A follow-up instruction that reads the register must then fault. Integer and float conversions are checked against extended encodings that the bench works out by hand. Register forms are swept over every index against a bench-side stack model.

// File: rtl/fpstk_pkg.sv
// Package: shared types and the extended-precision normaliser.
// Assumes an 80-bit target format: sign, 15-bit exponent, 64-bit significand.
package fpstk_pkg;
    localparam int EXT_W   = 80;
    localparam int EXT_BIAS = 16383;

    localparam logic [7:0] OP_MUL_S  = 8'hD8;
    localparam logic [7:0] OP_MUL_I32 = 8'hDA;
    localparam logic [7:0] OP_MUL_D  = 8'hDC;
    localparam logic [7:0] OP_MUL_P  = 8'hDE;

    typedef enum logic [2:0] {SRC_REG, SRC_F32, SRC_F64, SRC_I32, SRC_I16} src_fmt_e;
    typedef enum logic {DSP_IDLE, DSP_WAIT} dsp_state_e;

    typedef struct packed {
        logic      is_mul;
        logic      is_reg;
        src_fmt_e  fmt;
        logic [2:0] sti;
        logic      dst_sti;
        logic      pop;
    } dec_t;

    // Value = mag * 2^(base - EXT_BIAS - 63); shifts mag left until bit 63 is set.
    function automatic logic [EXT_W-1:0] ext_norm(input logic sgn, input logic [63:0] mag,
                                                  input int base);
        int   lz;
        logic seen;
        lz   = 0;
        seen = 1'b0;
        for (int b = 63; b >= 0; b--) begin
            if (!seen) begin
                if (mag[b]) seen = 1'b1;
                else        lz   = lz + 1;
            end
        end
        if (mag == 64'd0) return {sgn, 79'd0};
        return {sgn, 15'(base - lz), mag << lz};
    endfunction
endpackage

// File: rtl/fpstk_decode.sv
// Decoder: classifies an opcode/addressing-byte pair as one of the multiply forms.
// Assumes only the middle field value 1 selects multiply; everything else is inert.
module fpstk_decode
    import fpstk_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    output dec_t       dec
);
    logic       reg_mode;
    logic       mid_ok;

    assign reg_mode = (modrm[7:6] == 2'b11);
    assign mid_ok   = (modrm[5:3] == 3'd1);

    // Pick form, operand format, destination and pop for the encoding.
    always_comb begin
        dec         = '0;
        dec.sti     = modrm[2:0];
        dec.fmt     = SRC_REG;
        if (mid_ok) begin
            dec.is_reg = reg_mode;
            unique case (opcode)
                OP_MUL_S: begin
                    dec.is_mul = 1'b1;
                    dec.fmt    = reg_mode ? SRC_REG : SRC_F32;
                end
                OP_MUL_D: begin
                    dec.is_mul  = 1'b1;
                    dec.fmt     = reg_mode ? SRC_REG : SRC_F64;
                    dec.dst_sti = reg_mode;
                end
                OP_MUL_P: begin
                    dec.is_mul  = 1'b1;
                    dec.fmt     = reg_mode ? SRC_REG : SRC_I16;
                    dec.dst_sti = reg_mode;
                    dec.pop     = reg_mode;
                end
                OP_MUL_I32: begin
                    dec.is_mul = !reg_mode;
                    dec.fmt    = SRC_I32;
                end
                default: dec.is_mul = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fpstk_cvt.sv
// Converter: turns a low-aligned memory operand into extended precision.
// Assumes the format tag from the decoder; register forms yield zero (unused).
module fpstk_cvt
    import fpstk_pkg::*;
(
    input  src_fmt_e         fmt,
    input  logic [63:0]      mem,
    output logic [EXT_W-1:0] ext
);
    localparam int BASE = EXT_BIAS + 63;

    logic [31:0] i32_mag;
    logic [15:0] i16_mag;

    assign i32_mag = mem[31] ? (~mem[31:0] + 32'd1) : mem[31:0];
    assign i16_mag = mem[15] ? (~mem[15:0] + 16'd1) : mem[15:0];

    // Select the conversion for the operand format.
    always_comb begin
        unique case (fmt)
            SRC_F32: begin
                if (mem[30:23] == 8'hFF)
                    ext = {mem[31], 15'h7FFF, 1'b1, mem[22:0], 40'd0};
                else
                    ext = ext_norm(mem[31], {40'd0, (mem[30:23] != 8'd0), mem[22:0]},
                                   BASE + ((mem[30:23] == 8'd0) ? 1 : int'(mem[30:23])) - 150);
            end
            SRC_F64: begin
                if (mem[62:52] == 11'h7FF)
                    ext = {mem[63], 15'h7FFF, 1'b1, mem[51:0], 11'd0};
                else
                    ext = ext_norm(mem[63], {11'd0, (mem[62:52] != 11'd0), mem[51:0]},
                                   BASE + ((mem[62:52] == 11'd0) ? 1 : int'(mem[62:52])) - 1075);
            end
            SRC_I32: ext = ext_norm(mem[31], {32'd0, i32_mag}, BASE);
            SRC_I16: ext = ext_norm(mem[15], {48'd0, i16_mag}, BASE);
            default: ext = '0;
        endcase
    end
endmodule

// File: rtl/fpstk_regfile.sv
// Register stack: data, valid tags and a wrapping top pointer.
// Assumes push and commit never coincide; on commit the pop clears after the write.
module fpstk_regfile
    import fpstk_pkg::*;
#(
    parameter int NREG = 8,
    localparam int TW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [EXT_W-1:0] push_data,
    input  logic             wr_en,
    input  logic [TW-1:0]    wr_idx,
    input  logic [EXT_W-1:0] wr_data,
    input  logic             pop_en,
    input  logic [TW-1:0]    rd_b_idx,
    output logic [EXT_W-1:0] rd_a,
    output logic [EXT_W-1:0] rd_b,
    output logic [TW-1:0]    top,
    output logic [NREG-1:0]  tags
);
    logic [EXT_W-1:0] val [NREG];
    logic [TW-1:0]    push_idx;

    assign push_idx = top - TW'(1);
    assign rd_a     = val[top];
    assign rd_b     = val[rd_b_idx];

    // Move the top pointer on push (down) or popping commit (up).
    always_ff @(posedge clk) begin
        if (!rst_n)                top <= '0;
        else if (push_en)          top <= push_idx;
        else if (wr_en && pop_en)  top <= top + TW'(1);
    end

    for (genvar k = 0; k < NREG; k++) begin : g_ent
        // Hold one register's value, written by push or commit.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  val[k] <= '0;
            else if (push_en && push_idx == TW'(k))      val[k] <= push_data;
            else if (wr_en && wr_idx == TW'(k))          val[k] <= wr_data;
        end
        // Track one register's tag; a pop of this entry overrides a write to it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                        tags[k] <= 1'b0;
            else if (push_en && push_idx == TW'(k))            tags[k] <= 1'b1;
            else if (wr_en && pop_en && top == TW'(k))         tags[k] <= 1'b0;
            else if (wr_en && wr_idx == TW'(k))                tags[k] <= 1'b1;
        end
    end
endmodule

// File: rtl/fpstk_mul_dispatch.sv
// Top: accepts one multiply at a time, checks operand tags, issues the request,
// and commits the product with an optional pop. Assumes the multiplier answers
// exactly once per request, no earlier than the cycle after it.
module fpstk_mul_dispatch
    import fpstk_pkg::*;
#(
    parameter int NREG = 8,
    localparam int TW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_opcode,
    input  logic [7:0]       in_modrm,
    input  logic [63:0]      in_mem,
    input  logic             ld_valid,
    input  logic [EXT_W-1:0] ld_data,
    output logic             mul_req_valid,
    output logic [EXT_W-1:0] mul_req_a,
    output logic [EXT_W-1:0] mul_req_b,
    input  logic             mul_rsp_valid,
    input  logic [EXT_W-1:0] mul_rsp_data,
    input  logic             mul_rsp_c1,
    output logic             flt_stack,
    output logic             flg_c1,
    output logic [TW-1:0]    stk_top,
    output logic [NREG-1:0]  stk_tags
);
    dsp_state_e       state;
    dec_t             dec;
    logic [EXT_W-1:0] cvt_val, rd_a, rd_b;
    logic [TW-1:0]    idx_i, dest_q;
    logic             pop_q, accept, uflow, issue, fault, commit, push_en;

    fpstk_decode u_dec (.opcode(in_opcode), .modrm(in_modrm), .dec(dec));
    fpstk_cvt    u_cvt (.fmt(dec.fmt), .mem(in_mem), .ext(cvt_val));

    fpstk_regfile #(.NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_data(ld_data),
        .wr_en(commit), .wr_idx(dest_q), .wr_data(mul_rsp_data), .pop_en(pop_q),
        .rd_b_idx(idx_i), .rd_a(rd_a), .rd_b(rd_b),
        .top(stk_top), .tags(stk_tags)
    );

    assign in_ready = (state == DSP_IDLE) && !ld_valid;
    assign push_en  = ld_valid && (state == DSP_IDLE);
    assign accept   = in_valid && in_ready;
    assign idx_i    = stk_top + TW'(dec.sti);
    assign uflow    = !stk_tags[stk_top] || (dec.is_reg && !stk_tags[idx_i]);
    assign issue    = accept && dec.is_mul && !uflow;
    assign fault    = accept && dec.is_mul && uflow;
    assign commit   = (state == DSP_WAIT) && mul_rsp_valid;

    // Sequence: idle until a good multiply is issued, wait until its product commits.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= DSP_IDLE;
        else if (issue)   state <= DSP_WAIT;
        else if (commit)  state <= DSP_IDLE;
    end

    // Capture operands, destination and pop choice at issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mul_req_valid <= 1'b0;
            mul_req_a     <= '0;
            mul_req_b     <= '0;
            dest_q        <= '0;
            pop_q         <= 1'b0;
        end else begin
            mul_req_valid <= issue;
            if (issue) begin
                mul_req_a <= rd_a;
                mul_req_b <= dec.is_reg ? rd_b : cvt_val;
                dest_q    <= dec.dst_sti ? idx_i : stk_top;
                pop_q     <= dec.pop;
            end
        end
    end

    // Report the underflow pulse and maintain condition bit C1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_stack <= 1'b0;
            flg_c1    <= 1'b0;
        end else begin
            flt_stack <= fault;
            if (fault)       flg_c1 <= 1'b0;
            else if (commit) flg_c1 <= mul_rsp_c1;
        end
    end
endmodule

// File: rtl/fpstk_mul_dispatch_chk.sv
// Checker: port-level properties of the dispatcher, bound to every instance.
module fpstk_mul_dispatch_chk #(
    parameter int NREG = 8,
    localparam int TW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_ready,
    input logic            ld_valid,
    input logic            mul_req_valid,
    input logic            flt_stack,
    input logic            flg_c1,
    input logic [TW-1:0]   stk_top,
    input logic [NREG-1:0] stk_tags
);
    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mul_req_valid |=> !mul_req_valid);                                   // R10
    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        mul_req_valid |-> !in_ready);                                        // R10
    AST_FAULT_CLEARS_C1: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stack |-> !flg_c1);                                              // R8
    AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stack |-> !mul_req_valid);                                       // R8
    AST_FAULT_STACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stack |-> ($stable(stk_top) && $stable(stk_tags)));              // R8
    AST_PUSH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !in_ready);                                             // R2
endmodule

bind fpstk_mul_dispatch fpstk_mul_dispatch_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .ld_valid(ld_valid),
    .mul_req_valid(mul_req_valid), .flt_stack(flt_stack), .flg_c1(flg_c1),
    .stk_top(stk_top), .stk_tags(stk_tags)
);

// File: tb/fpstk_mul_dispatch_tb_top.sv
module fpstk_mul_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_opcode = '0;
    logic [7:0]  in_modrm = '0;
    logic [63:0] in_mem = '0;
    logic        ld_valid = 1'b0;
    logic [79:0] ld_data = '0;
    logic        mul_req_valid;
    logic [79:0] mul_req_a, mul_req_b;
    logic        mul_rsp_valid = 1'b0;
    logic [79:0] mul_rsp_data = '0;
    logic        mul_rsp_c1 = 1'b0;
    logic        flt_stack, flg_c1;
    logic [2:0]  stk_top;
    logic [7:0]  stk_tags;

    int n_chk = 0;
    int n_err = 0;

    logic [79:0] m_val [8];
    bit          m_tag [8];
    int          m_top = 0;
    bit          m_c1 = 0;

    always #2 clk = ~clk;

    fpstk_mul_dispatch dut_i (.*);

    task automatic chk(input bit ok, input string rq, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] m_tagvec();
        logic [7:0] v;
        for (int p = 0; p < 8; p++) v[p] = m_tag[p];
        return v;
    endfunction

    task automatic chk_stack(input string rq);
        chk(stk_top == 3'(m_top), {rq, " top"}, 80'(stk_top), 80'(m_top));
        chk(stk_tags == m_tagvec(), {rq, " tags"}, 80'(stk_tags), 80'(m_tagvec()));
    endtask

    task automatic push(input logic [79:0] v);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_data  = v;
        #1;
        chk(in_ready == 1'b0, "R2 ready low during push", 80'(in_ready), 80'(0));
        @(negedge clk);
        ld_valid = 1'b0;
        m_top = (m_top + 7) % 8;
        m_val[m_top] = v;
        m_tag[m_top] = 1'b1;
        chk_stack("R2 push");
    endtask

    task automatic mul_op(input logic [7:0] op, input logic [7:0] mrm, input logic [63:0] mem,
                          input logic [79:0] mem_ext, input logic [79:0] rsp, input bit c1,
                          input string rq);
        bit rmode, is_mul, pop, uf;
        int i, dest, si;
        logic [79:0] exp_b;
        rmode  = (mrm[7:6] == 2'b11);
        i      = int'(mrm[2:0]);
        si     = (m_top + i) % 8;
        is_mul = (mrm[5:3] == 3'd1) &&
                 (op == 8'hD8 || op == 8'hDC || op == 8'hDE || (op == 8'hDA && !rmode));
        pop    = rmode && (op == 8'hDE);
        if (rmode) begin
            dest  = (op == 8'hD8) ? m_top : si;
            exp_b = m_val[si];
            uf    = !m_tag[m_top] || !m_tag[si];
        end else begin
            dest  = m_top;
            exp_b = mem_ext;
            uf    = !m_tag[m_top];
        end
        @(negedge clk);
        chk(in_ready == 1'b1, {rq, " R10 ready when idle"}, 80'(in_ready), 80'(1));
        in_valid = 1'b1; in_opcode = op; in_modrm = mrm; in_mem = mem;
        @(negedge clk);
        in_valid = 1'b0;
        if (!is_mul) begin
            chk(!mul_req_valid && !flt_stack, {rq, " R11 no effect"},
                80'({mul_req_valid, flt_stack}), 80'(0));
            chk_stack({rq, " R11"});
        end else if (uf) begin
            chk(flt_stack && !mul_req_valid, {rq, " R8 fault pulse"},
                80'({flt_stack, mul_req_valid}), 80'(2));
            m_c1 = 1'b0;
            chk(flg_c1 == 1'b0, {rq, " R8 C1 cleared"}, 80'(flg_c1), 80'(0));
            @(negedge clk);
            chk(!flt_stack, {rq, " R8 single pulse"}, 80'(flt_stack), 80'(0));
            chk_stack({rq, " R8 stack held"});
        end else begin
            chk(mul_req_valid == 1'b1, {rq, " R10 request"}, 80'(mul_req_valid), 80'(1));
            chk(mul_req_a == m_val[m_top], {rq, " R3 operand a"}, mul_req_a, m_val[m_top]);
            chk(mul_req_b == exp_b, {rq, " R4/R5/R6 operand b"}, mul_req_b, exp_b);
            @(negedge clk);
            chk(!mul_req_valid && !in_ready, {rq, " R10 busy"},
                80'({mul_req_valid, in_ready}), 80'(0));
            mul_rsp_valid = 1'b1; mul_rsp_data = rsp; mul_rsp_c1 = c1;
            @(negedge clk);
            mul_rsp_valid = 1'b0;
            m_val[dest] = rsp;
            m_tag[dest] = 1'b1;
            if (pop) begin
                m_tag[m_top] = 1'b0;
                m_top = (m_top + 1) % 8;
            end
            m_c1 = c1;
            chk_stack({rq, " R7 commit"});
            chk(flg_c1 == m_c1, {rq, " R9 C1"}, 80'(flg_c1), 80'(m_c1));
            chk(in_ready == 1'b1, {rq, " R10 ready after commit"}, 80'(in_ready), 80'(1));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        for (int p = 0; p < 8; p++) begin m_val[p] = '0; m_tag[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stk_top == 0 && stk_tags == 0, "R1 reset stack", 80'({stk_top, stk_tags}), 80'(0));
        chk(in_ready && !mul_req_valid && !flt_stack && !flg_c1, "R1 reset outputs",
            80'({in_ready, mul_req_valid, flt_stack, flg_c1}), 80'(8));

        mul_op(8'hD8, 8'hC9, 64'd0, 80'd0, 80'd0, 1'b0, "empty D8");
        for (int k = 0; k < 8; k++) push(80'h1000 + 80'(k));

        for (int i = 0; i < 8; i++)
            mul_op(8'hD8, 8'hC8 + 8'(i), 64'd0, 80'd0, 80'hA000 + 80'(i), i[0], "sweep D8");
        for (int i = 0; i < 8; i++)
            mul_op(8'hDC, 8'hC8 + 8'(i), 64'd0, 80'd0, 80'hB000 + 80'(i), i[0], "sweep DC");

        mul_op(8'hD8, 8'h08, 64'h3F800000, 80'h3FFF_8000000000000000, 80'hC001, 0, "R5 f32 1.0");
        mul_op(8'hD8, 8'h48, 64'hC0200000, 80'hC000_A000000000000000, 80'hC002, 0, "R5 f32 -2.5");
        mul_op(8'hD8, 8'h88, 64'h00000001, 80'h3F6A_8000000000000000, 80'hC003, 0, "R5 f32 denormal");
        mul_op(8'hD8, 8'h08, 64'h7F800000, 80'h7FFF_8000000000000000, 80'hC004, 0, "R5 f32 inf");
        mul_op(8'hDC, 8'h08, 64'h3FF0000000000000, 80'h3FFF_8000000000000000, 80'hC005, 0, "R5 f64 1.0");
        mul_op(8'hDC, 8'h0D, 64'hBFE0000000000000, 80'hBFFE_8000000000000000, 80'hC006, 0, "R5 f64 -0.5");
        mul_op(8'hDA, 8'h08, 64'h5, 80'h4001_A000000000000000, 80'hC007, 0, "R6 i32 5");
        mul_op(8'hDA, 8'h08, 64'h0, 80'h0, 80'hC008, 0, "R6 i32 zero");
        mul_op(8'hDA, 8'h08, 64'hFFFFFFFF, 80'hBFFF_8000000000000000, 80'hC009, 0, "R6 i32 -1");
        mul_op(8'hDE, 8'h08, 64'hFFFD, 80'hC000_C000000000000000, 80'hC00A, 0, "R6 i16 -3");
        mul_op(8'hDE, 8'h08, 64'h7FFF, 80'h400D_FFFE000000000000, 80'hC00B, 1, "R6 i16 max");

        mul_op(8'hD8, 8'hC1, 64'd0, 80'd0, 80'd0, 0, "R11 mid field 0");
        mul_op(8'hDA, 8'hC9, 64'd0, 80'd0, 80'd0, 0, "R11 DA reg mode");
        mul_op(8'hD9, 8'hC9, 64'd0, 80'd0, 80'd0, 0, "R11 other opcode");
        mul_op(8'hDC, 8'h10, 64'd0, 80'd0, 80'd0, 0, "R11 DC mid 2");

        mul_op(8'hDE, 8'hC9, 64'd0, 80'd0, 80'hD001, 1, "R7 DE pop i1");
        mul_op(8'hDE, 8'hC8, 64'd0, 80'd0, 80'hD002, 1, "R7 DE pop onto self");
        for (int n = 0; n < 7; n++)
            mul_op(8'hDE, 8'hC9, 64'd0, 80'd0, 80'hD010 + 80'(n), 1, "R7 pop chain");
        mul_op(8'hDE, 8'hC8, 64'd0, 80'd0, 80'hD020, 1, "R7 last pop");
        mul_op(8'hD8, 8'hC8, 64'd0, 80'd0, 80'd0, 0, "R8 empty after pops");

        push(80'h2222);
        push(80'h3333);
        mul_op(8'hDC, 8'hC9, 64'd0, 80'd0, 80'hE001, 0, "R4 DC after refill");
        mul_op(8'hD8, 8'hC9, 64'd0, 80'd0, 80'hE002, 1, "R3 readback ST1");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule